// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the byte stream of an incoming Ethernet frame and decides, from the destination address alone, whether the frame should be kept. The receive datapath presents one byte per cycle with a valid qualifier. The first byte of every frame carries a start marker. The filter consumes the first six bytes and ignores the rest of the frame.

Three checks run in parallel while the address streams past. The first is an exact compare against a programmed 48-bit station address. The second is a hash lookup into a 64-bit group filter for multicast destinations. The third detects the all-ones broadcast address. None of them buffers the address: each keeps running state only (match flags and a CRC register). One cycle after the sixth byte, a strobe presents the verdict, the kind of match and the address class. A promiscuous control forces acceptance.

Top module: `dst_addr_filter`

## Requirements
- R1: `dec_valid_o` is high for exactly one cycle, in the cycle after the sixth address byte of a frame is taken. It is low at every other time.
- R2: A byte with `byte_valid_i` and `sof_i` both high is always taken as address byte 0. This holds even when an earlier address is only partly received, so the earlier frame is abandoned without a decision.
- R3: Valid bytes after the sixth address byte, and valid bytes seen before any start marker, are ignored. They cause no strobe and do not change the next decision.
- R4: An address whose group bit (bit 0 of byte 0) is 0 is accepted only when every byte k equals `phys_addr_i[8k+7:8k]`. Such an acceptance reports `match_type_o` = 1. Any differing byte rejects the frame with `match_type_o` = 0.
- R5: A group address that is not all ones sets `is_mcast_o`. Its hash index is bits [31:26] of a CRC register computed as follows: start at all ones, shift each byte in least significant bit first using the reflected polynomial 0xEDB88320, and apply no final inversion. The frame is accepted with `match_type_o` = 2 only when `hash_table_i[index]` is 1.
- R6: An all-0xFF address sets `is_bcast_o` and clears `is_mcast_o`. It is accepted with `match_type_o` = 3 when `bcast_en_i` is 1, and rejected otherwise. `hash_table_i` never affects it.
- R7: When `promisc_i` is 1, `accept_o` is 1 for every decision. `match_type_o` still reports the result of the address checks.
- R8: After reset all outputs are 0. `accept_o`, `match_type_o`, `is_bcast_o` and `is_mcast_o` hold their values until the next decision.
- R9: Cycles with `byte_valid_i` low between address bytes have no effect on the decision. Control inputs are used as they are in the cycle of the sixth byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Byte qualifier |
| sof_i | input | 1 | Marks the first byte of a frame |
| byte_data_i | input | 8 | Received byte |
| phys_addr_i | input | 48 | Station address, byte k in bits 8k+7:8k |
| hash_table_i | input | 64 | Multicast group filter bits |
| bcast_en_i | input | 1 | Accept broadcast |
| promisc_i | input | 1 | Accept every frame |
| dec_valid_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted |
| match_type_o | output | 2 | 0 none, 1 unicast, 2 multicast hash, 3 broadcast |
| is_bcast_o | output | 1 | Address was broadcast |
| is_mcast_o | output | 1 | Address was non-broadcast group |

## Verification
The hardest case to reach from the ports is a multicast address whose hash lands on one chosen bit of the filter. The bench computes the index for each test address with its own bit-serial CRC loop. It then loads a filter that contains only that bit, followed by one that lacks only that bit, so a single address shows both acceptance and rejection. Abandoned partial addresses, idle gaps inside the address, and trailing payload containing 0xFF bytes are also driven, because they reveal state that is not reset on a new start marker.

// File: rtl/adf_pkg.sv
package adf_pkg;
  typedef enum logic [1:0] {
    MT_NONE  = 2'd0,
    MT_UCAST = 2'd1,
    MT_MCAST = 2'd2,
    MT_BCAST = 2'd3
  } match_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // byte enters lsb first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/adf_hash.sv
module adf_hash #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 take_i,
  input  logic                 first_i,
  input  logic [7:0]           data_i,
  output logic [HASH_BITS-1:0] idx_nx_o
);
  import adf_pkg::*;

  logic [31:0] crc_q, crc_in, crc_nx;

  assign crc_in   = first_i ? '1 : crc_q;
  assign crc_nx   = crc_byte(crc_in, data_i);
  assign idx_nx_o = crc_nx[31 -: HASH_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (take_i) crc_q <= crc_nx;
  end

  // R3
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(crc_q));
endmodule

// File: rtl/adf_match.sv
module adf_match #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    first_i,
  input  logic [CNT_W-1:0]        idx_i,
  input  logic [7:0]              data_i,
  input  logic [8*ADDR_BYTES-1:0] phys_addr_i,
  output logic                    ucast_nx_o,
  output logic                    bcast_nx_o
);
  localparam logic [CNT_W-1:0] N_C = CNT_W'(ADDR_BYTES);

  logic [7:0] lane [ADDR_BYTES];
  logic [7:0] ref_byte;
  logic       ucast_q, bcast_q, ucast_in, bcast_in;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    assign lane[k] = phys_addr_i[8*k +: 8];
  end

  assign ref_byte   = (idx_i < N_C) ? lane[idx_i] : 8'h00;
  assign ucast_in   = first_i ? 1'b1 : ucast_q;
  assign bcast_in   = first_i ? 1'b1 : bcast_q;
  assign ucast_nx_o = ucast_in & (data_i == ref_byte);
  assign bcast_nx_o = bcast_in & (&data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucast_q <= 1'b0;
      bcast_q <= 1'b0;
    end else if (take_i) begin
      ucast_q <= ucast_nx_o;
      bcast_q <= bcast_nx_o;
    end
  end

  // R6
  bcast_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && first_i && data_i != 8'hFF) |=> !bcast_q);
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      byte_valid_i,
  input  logic                      sof_i,
  input  logic [7:0]                byte_data_i,
  input  logic [8*ADDR_BYTES-1:0]   phys_addr_i,
  input  logic [(1<<HASH_BITS)-1:0] hash_table_i,
  input  logic                      bcast_en_i,
  input  logic                      promisc_i,
  output logic                      dec_valid_o,
  output logic                      accept_o,
  output logic [1:0]                match_type_o,
  output logic                      is_bcast_o,
  output logic                      is_mcast_o
);
  import adf_pkg::*;

  localparam int               CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] N_C   = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]     cnt_q, cur_idx;
  logic                 first, take, last;
  logic                 grp_q, grp_nx;
  logic                 ucast_nx, bcast_nx, is_m_nx;
  logic [HASH_BITS-1:0] hidx;
  match_t               mt_nx, mt_q;
  logic                 acc_nx;
  logic                 dv_q, acc_q, b_q, m_q;

  assign first   = byte_valid_i & sof_i;
  assign take    = byte_valid_i & (sof_i | (cnt_q < N_C));
  assign cur_idx = sof_i ? '0 : cnt_q;
  assign last    = take & (cur_idx == LAST);
  assign grp_nx  = sof_i ? byte_data_i[0] : grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= N_C;
      grp_q <= 1'b0;
    end else begin
      if (first)     cnt_q <= CNT_W'(1);
      else if (take) cnt_q <= cnt_q + 1'b1;
      if (first)     grp_q <= byte_data_i[0];
    end
  end

  adf_hash #(.HASH_BITS(HASH_BITS)) hash_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .first_i (first),
    .data_i  (byte_data_i),
    .idx_nx_o(hidx)
  );

  adf_match #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) match_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .first_i    (first),
    .idx_i      (cur_idx),
    .data_i     (byte_data_i),
    .phys_addr_i(phys_addr_i),
    .ucast_nx_o (ucast_nx),
    .bcast_nx_o (bcast_nx)
  );

  // broadcast wins over the hash lookup
  assign is_m_nx = grp_nx & ~bcast_nx;
  always_comb begin
    if (bcast_nx)     mt_nx = bcast_en_i ? MT_BCAST : MT_NONE;
    else if (is_m_nx) mt_nx = hash_table_i[hidx] ? MT_MCAST : MT_NONE;
    else              mt_nx = ucast_nx ? MT_UCAST : MT_NONE;
  end
  assign acc_nx = promisc_i | (mt_nx != MT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      acc_q <= 1'b0;
      mt_q  <= MT_NONE;
      b_q   <= 1'b0;
      m_q   <= 1'b0;
    end else begin
      dv_q <= last;
      if (last) begin
        acc_q <= acc_nx;
        mt_q  <= mt_nx;
        b_q   <= bcast_nx;
        m_q   <= is_m_nx;
      end
    end
  end

  assign dec_valid_o  = dv_q;
  assign accept_o     = acc_q;
  assign match_type_o = mt_q;
  assign is_bcast_o   = b_q;
  assign is_mcast_o   = m_q;

  // R1
  dec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  // R1
  dec_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i));
  // R6
  class_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_bcast_o && is_mcast_o));
  // R6
  bcast_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_type_o == MT_BCAST) |-> is_bcast_o);
  // R7
  accept_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !$past(promisc_i)) |-> (accept_o == (match_type_o != MT_NONE)));
endmodule

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0, sof = 1'b0;
  logic [7:0]  bd = 8'h00;
  logic [47:0] phys = 48'h665544332210;
  logic [63:0] ht = '0;
  logic        ben = 1'b0, prom = 1'b0;
  logic        dv, acc, ib, im;
  logic [1:0]  mt;

  int    total = 0, bad = 0;
  bit    done = 0;
  string cur_tag = "R3";

  always #5 clk = ~clk;

  dst_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .sof_i(sof), .byte_data_i(bd),
    .phys_addr_i(phys), .hash_table_i(ht), .bcast_en_i(ben), .promisc_i(prom),
    .dec_valid_o(dv), .accept_o(acc), .match_type_o(mt), .is_bcast_o(ib), .is_mcast_o(im)
  );

  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return int'(c[31:26]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int          nb = 6;
  logic [47:0] abuf = '0;
  int          e_v = 0, e_acc = 0, e_mt = 0, e_b = 0, e_m = 0;
  string       e_tag = "R8";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb = 6; e_v = 0; e_acc = 0; e_mt = 0; e_b = 0; e_m = 0;
    end else begin
      e_v = 0;
      if (bv && (sof || nb < 6)) begin
        if (sof) nb = 0;
        abuf[8*nb +: 8] = bd;
        nb++;
        if (nb == 6) begin
          e_v = 1;
          e_b = (abuf == '1) ? 1 : 0;
          e_m = (abuf[0] && !e_b) ? 1 : 0;
          if (e_b != 0)      begin e_mt = ben ? 3 : 0; e_tag = "R6"; end
          else if (e_m != 0) begin e_mt = ht[ref_idx(abuf)] ? 2 : 0; e_tag = "R5"; end
          else               begin e_mt = (abuf == phys) ? 1 : 0; e_tag = "R4"; end
          e_acc = (prom || e_mt != 0) ? 1 : 0;
          if (prom) e_tag = "R7";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({"R1/", cur_tag, " dec_valid"}, int'(dv), e_v);
      chk({e_tag, "/", cur_tag, " accept"}, int'(acc), e_acc);
      chk({e_tag, "/", cur_tag, " match_type"}, int'(mt), e_mt);
      chk({"R6/", e_tag, " is_bcast"}, int'(ib), e_b);
      chk({"R5/", e_tag, " is_mcast"}, int'(im), e_m);
    end
  end

  task automatic send_byte(input logic [7:0] d, input logic s);
    @(negedge clk);
    bv = 1'b1; sof = s; bd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bv = 1'b0; sof = 1'b0; bd = 8'hA5;
    end
  endtask

  task automatic send_addr(input logic [47:0] a, input int gap, input int tail);
    for (int k = 0; k < 6; k++) begin
      send_byte(a[8*k +: 8], k == 0);
      if (gap > 0) idle(gap);
    end
    for (int t = 0; t < tail; t++) send_byte(8'hFF - 8'(t * 3), 1'b0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] ma, mb;
    int          ia;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 dec_valid", int'(dv), 0);
    chk("R8 accept", int'(acc), 0);
    chk("R8 match_type", int'(mt), 0);
    chk("R8 flags", int'({ib, im}), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    cur_tag = "R3";
    for (int i = 0; i < 7; i++) send_byte(phys[8*(i%6) +: 8], 1'b0);
    idle(3);

    cur_tag = "R4";
    send_addr(phys, 0, 0);                   idle(2);
    send_addr(phys ^ (48'h1 << 44), 0, 0);   idle(2);
    send_addr(phys ^ 48'h02, 0, 0);          idle(2);
    phys = 48'hCAFE12345678;
    send_addr(48'hCAFE12345678, 0, 3);       idle(2);

    cur_tag = "R5";
    ma = 48'h0302015E0001;
    mb = 48'hDDCCBBAA9933;
    ia = ref_idx(ma);
    ht = 64'h1 << ia;    send_addr(ma, 0, 0); idle(2);
    ht = ~(64'h1 << ia); send_addr(ma, 0, 0); idle(2);
    ia = ref_idx(mb);
    ht = 64'h1 << ia;    send_addr(mb, 1, 0); idle(2);
    ht = 64'hF0F0_3C3C_A5A5_0FF0; send_addr(mb, 0, 0); idle(2);

    cur_tag = "R6";
    ht = '1; ben = 1'b1; send_addr('1, 0, 0); idle(2);
    ben = 1'b0;          send_addr('1, 0, 0); idle(2);
    ht = '0; ben = 1'b1; send_addr('1, 0, 0); idle(2);
    send_addr(48'hFFFFFFFFFF7F, 0, 0);        idle(2);

    cur_tag = "R7";
    prom = 1'b1;
    send_addr(48'h112233445566, 0, 0); idle(2);
    ben = 1'b0; send_addr('1, 0, 0);   idle(2);
    prom = 1'b0;

    cur_tag = "R9";
    send_addr(phys, 2, 0); idle(2);
    ht = 64'h1 << ref_idx(ma);
    send_addr(ma, 3, 0);   idle(2);

    cur_tag = "R2";
    send_byte(8'hFF, 1'b1); send_byte(8'hFF, 1'b0); send_byte(8'hFF, 1'b0);
    send_addr(phys, 0, 0); idle(2);
    for (int k = 0; k < 5; k++) send_byte(phys[8*k +: 8], k == 0);
    send_addr(ma, 0, 0);   idle(2);

    cur_tag = "R3";
    ben = 1'b1;
    send_addr(phys ^ 48'h0400, 0, 12);
    send_addr('1, 0, 6);
    send_addr(phys, 0, 0); idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule